// File: doc/BRIEF.md
# Push-Button Status Register with Interrupt Request

This block is a read-only input port for a small 8-bit soft processor. Five push-buttons (Select, Right, Left, Up, Down) feed a synchronizer and a rising-edge detector. Each new press is caught into a status byte and sets a sticky "press pending" flag. The same press raises an interrupt request, so firmware can service the buttons in an interrupt routine and does not need to poll.

The processor clears the pending state in one of two ways. It can read the register through its input port, which is a read strobe qualified by a register-select line from the external address decoder. It can also acknowledge the interrupt. The interrupt line is released only by the acknowledge. A button that is held down produces one request, and it produces another only after it is released and pressed again.

Top module: `btn_status_reg`

## Requirements
- R1: After reset the status byte reads 0x00 and `irq` is low.
- R2: A button whose raw input goes from 0 to 1 and stays high sets the pending flag (bit 7) and its own button bit. The change is visible on the outputs after the third rising clock edge that samples the new level.
- R3: The status byte layout is: bit 7 pending flag, bit 4 Select, bit 3 Right, bit 2 Left, bit 1 Up, bit 0 Down. Bits 6 and 5 always read 0. The raw input `btn_raw[4:0]` uses the same bit order.
- R4: A clock edge with `rd_strobe` and `rd_sel` both high clears the pending flag and all button bits. `rd_strobe` with `rd_sel` low clears nothing.
- R5: A clock edge with `irq_ack` high clears the pending flag, all button bits and `irq`.
- R6: `irq` rises on the same edge as the pending flag for a press. It stays high through port reads until an acknowledge arrives.
- R7: A button held high after its press has been cleared causes no new pending flag and no new `irq`. A release followed by a new press does.
- R8: When a new press and a clearing event (read or acknowledge) land on the same edge, the pending flag and `irq` stay set, and the button bits hold only the newly pressed buttons.
- R9: Presses on further buttons while the flag is pending add their bits to the ones already latched.
- R10: `rd_data` is 0x00 whenever `rd_sel` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| btn_raw | input | 5 | Raw button levels, bit 4 Select down to bit 0 Down |
| rd_strobe | input | 1 | Processor port-read strobe |
| rd_sel | input | 1 | Register-select decode for this register |
| irq_ack | input | 1 | Interrupt acknowledge |
| rd_data | output | 8 | Status byte while selected, else zero |
| irq | output | 1 | Interrupt request |

## Verification
A level change on `btn_raw` reaches the status byte and `irq` on the third rising edge after it is applied. A read or an acknowledge takes effect on the first edge that samples it. `rd_data` follows `rd_sel` with no clock delay. The bench drives every input on the falling edge and checks `rd_data` and `irq` just after that falling edge. It holds a three-deep history of the applied button levels, so its expected state already includes every edge the design has taken. Directed sequences place a clearing event on exactly the edge where a press is detected, and they hold a button through an acknowledge.

// File: rtl/btn_pkg.sv
package btn_pkg;
    localparam int BTN_N    = 5;
    localparam int REG_W    = 8;
    localparam int FLAG_POS = REG_W - 1;

    typedef struct packed {
        logic             pend;
        logic [BTN_N-1:0] hit;
        logic             irq;
    } core_state_t;
endpackage

// File: rtl/btn_edge_sync.sv
module btn_edge_sync #(
    parameter int N      = 5,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] raw_i,
    output logic [N-1:0] rise_o
);
    typedef struct packed {
        logic [STAGES-1:0][N-1:0] pipe;
        logic [N-1:0]             prev;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.pipe[0] = raw_i;
        for (int s = 1; s < STAGES; s++) begin
            st_d.pipe[s] = st_q.pipe[s-1];
        end
        st_d.prev = st_q.pipe[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rise_o = st_q.pipe[STAGES-1] & ~st_q.prev;

    AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_o != '0) |=> ((rise_o & $past(rise_o)) == '0)); // R7
endmodule

// File: rtl/btn_status_core.sv
module btn_status_core
    import btn_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [BTN_N-1:0] rise_i,
    input  logic             clr_rd_i,
    input  logic             clr_ack_i,
    output logic [REG_W-1:0] status_o,
    output logic             irq_o
);
    core_state_t st_d, st_q;
    logic        any_rise;
    logic        any_clr;

    always_comb begin
        any_rise = |rise_i;
        any_clr  = clr_rd_i | clr_ack_i;
        st_d     = st_q;
        if (any_rise) begin
            st_d.pend = 1'b1;
            st_d.hit  = (any_clr ? '0 : st_q.hit) | rise_i;
            st_d.irq  = 1'b1;
        end else begin
            if (any_clr) begin
                st_d.pend = 1'b0;
                st_d.hit  = '0;
            end
            if (clr_ack_i) st_d.irq = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        status_o              = '0;
        status_o[FLAG_POS]    = st_q.pend;
        status_o[BTN_N-1:0]   = st_q.hit;
    end
    assign irq_o = st_q.irq;

    AST_HIT_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.hit != '0) |-> st_q.pend); // R2
    AST_PRESS_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_i != '0) |=> (st_q.pend && st_q.irq)); // R6
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_ack_i && rise_i == '0) |=> (!st_q.irq && !st_q.pend && st_q.hit == '0)); // R5
    AST_READ_KEEPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_rd_i && !clr_ack_i && st_q.irq) |=> st_q.irq); // R6
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_rd_i && rise_i == '0) |=> !st_q.pend); // R4
endmodule

// File: rtl/btn_rd_port.sv
module btn_rd_port
    import btn_pkg::*;
(
    input  logic             rd_strobe_i,
    input  logic             rd_sel_i,
    input  logic [REG_W-1:0] status_i,
    output logic             clr_rd_o,
    output logic [REG_W-1:0] rd_data_o
);
    always_comb begin
        clr_rd_o  = rd_strobe_i & rd_sel_i;
        rd_data_o = rd_sel_i ? status_i : '0;
    end
endmodule

// File: rtl/btn_status_reg.sv
module btn_status_reg
    import btn_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [BTN_N-1:0] btn_raw,
    input  logic             rd_strobe,
    input  logic             rd_sel,
    input  logic             irq_ack,
    output logic [REG_W-1:0] rd_data,
    output logic             irq
);
    logic [BTN_N-1:0] rise;
    logic [REG_W-1:0] status;
    logic             clr_rd;

    btn_edge_sync #(.N(BTN_N), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  (btn_raw),
        .rise_o (rise)
    );

    btn_status_core u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .rise_i    (rise),
        .clr_rd_i  (clr_rd),
        .clr_ack_i (irq_ack),
        .status_o  (status),
        .irq_o     (irq)
    );

    btn_rd_port u_port (
        .rd_strobe_i (rd_strobe),
        .rd_sel_i    (rd_sel),
        .status_i    (status),
        .clr_rd_o    (clr_rd),
        .rd_data_o   (rd_data)
    );

    AST_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[FLAG_POS-1:BTN_N] == '0); // R3
    AST_UNSEL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_sel |-> (rd_data == '0)); // R10
endmodule

// File: tb/tb_btn_status_reg.sv
`timescale 1ns/1ps
module tb_btn_status_reg;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] btn_raw = '0;
    logic       rd_strobe = 1'b0, rd_sel = 1'b0, irq_ack = 1'b0;
    logic [7:0] rd_data;
    logic       irq;

    int checks = 0, failures = 0;
    logic       done = 1'b0;

    // bench model: applied-level history and expected state
    logic [4:0] p0 = '0, p1 = '0, p2 = '0;
    logic       m_pend = 0, m_irq = 0;
    logic [4:0] m_hit = '0;
    string      last_tag = "R1";

    always #2.5 clk = ~clk;

    btn_status_reg dut (
        .clk(clk), .rst_n(rst_n), .btn_raw(btn_raw), .rd_strobe(rd_strobe),
        .rd_sel(rd_sel), .irq_ack(irq_ack), .rd_data(rd_data), .irq(irq)
    );

    function automatic logic [7:0] exp_byte(logic sel);
        logic [7:0] b;
        b = '0;
        b[7] = m_pend;
        b[4:0] = m_hit;
        return sel ? b : 8'h00;
    endfunction

    task automatic chk8(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=%02h exp=%02h t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic chk1(string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=%0b exp=%0b t=%0t", req, act, exp, $time);
        end
    endtask

    // one cycle: drive at negedge, check, then advance model at posedge
    task automatic step(logic [4:0] b, logic rd, logic sel, logic ack);
        logic [4:0] rise;
        logic clr;
        @(negedge clk);
        btn_raw = b; rd_strobe = rd; rd_sel = sel; irq_ack = ack;
        #1;
        chk8(sel ? last_tag : "R10", rd_data, exp_byte(sel));
        chk8("R3", rd_data & 8'h60, 8'h00);
        chk1(last_tag == "R5" ? "R5" : "R6", irq, m_irq);
        @(posedge clk);
        rise = p1 & ~p2;
        clr = (rd & sel) | ack;
        p2 = p1; p1 = p0; p0 = b;
        if (rise != 0) begin
            m_pend = 1; m_irq = 1;
            m_hit = (clr ? 5'b0 : m_hit) | rise;
        end else begin
            if (clr) begin m_pend = 0; m_hit = '0; end
            if (ack) m_irq = 0;
        end
        if (rise != 0 && clr)      last_tag = "R8";
        else if (ack)              last_tag = "R5";
        else if (rd & sel)         last_tag = "R4";
        else if (rise != 0)        last_tag = (m_hit != rise) ? "R9" : "R2";
        else                       last_tag = "R2";
    endtask

    initial begin
        #100000;
        if (!done) begin
            failures++; checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4321));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        rd_sel = 1'b1; #1;
        chk8("R1", rd_data, 8'h00);
        chk1("R1", irq, 1'b0);

        // R2: Up press appears on third edge
        step(5'b00010, 0, 1, 0);
        step(5'b00010, 0, 1, 0);
        step(5'b00010, 0, 1, 0);
        #1; chk8("R2", rd_data, 8'h82);
        // R9: add Select while pending
        repeat (4) step(5'b10010, 0, 1, 0);
        chk8("R9", rd_data, 8'h92);
        // R4: strobe without select clears nothing
        step(5'b10010, 1, 0, 0);
        step(5'b10010, 0, 1, 0);
        chk8("R4", rd_data, 8'h92);
        // R4/R6: real read clears flag, irq stays
        step(5'b10010, 1, 1, 0);
        step(5'b10010, 0, 1, 0);
        chk8("R4", rd_data, 8'h00);
        chk1("R6", irq, 1'b1);
        // R5: acknowledge clears irq
        step(5'b10010, 0, 1, 1);
        step(5'b10010, 0, 1, 0);
        chk1("R5", irq, 1'b0);
        // R7: held buttons never re-raise
        repeat (6) step(5'b10010, 0, 1, 0);
        chk1("R7", irq, 1'b0);
        chk8("R7", rd_data, 8'h00);
        // R7: release then press Down again
        repeat (3) step(5'b00000, 0, 1, 0);
        repeat (3) step(5'b00001, 0, 1, 0);
        #1; chk1("R7", irq, 1'b1);
        chk8("R7", rd_data, 8'h81);
        step(5'b00001, 0, 1, 1);
        // R8: Left press detected on the same edge as an ack
        step(5'b00101, 0, 1, 0);
        step(5'b00101, 0, 1, 0);
        step(5'b00101, 0, 1, 1);
        #1; chk8("R8", rd_data, 8'h84);
        chk1("R8", irq, 1'b1);
        // R8: Right press on the same edge as a read
        step(5'b01101, 0, 1, 0);
        step(5'b01101, 0, 1, 0);
        step(5'b01101, 1, 1, 0);
        #1; chk8("R8", rd_data, 8'h88);

        // constrained random
        for (int i = 0; i < 3000; i++) begin
            logic [4:0] b;
            logic r, s, a;
            b = (($urandom % 4) == 0) ? 5'($urandom) : btn_raw;
            r = ($urandom % 6) == 0;
            s = ($urandom % 3) != 0;
            a = ($urandom % 8) == 0;
            step(b, r, s, a);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule